// File: doc/BRIEF.md
# Half-Step Predivide Clock Generator

This block makes a programmable clock from one of three reference sources. It runs entirely in a fast system clock domain. Each reference arrives as a one-cycle tick enable that pulses at twice that reference's rate. A predivide stage counts 4, 5 or 6 of these ticks per step, which gives effective ratios of 2, 2.5 and 3 without any fractional arithmetic. An integer stage then divides the step stream by 2 to 127. The result is a square-wave level and a one-cycle tick on each rising transition. The output frequency is (2 × source rate) / (2 × predivide ratio × divide value).

A 16-bit control word is loaded through a write port. It carries the source select, the predivide code, the divide value and an enable bit. Writes go to a pending copy. The running copy takes the pending word only at the end of a complete output period, or at once while the output is idle, so a change never produces a runt pulse. A status output reports a word that is enabled but not usable.

Top module: `hsp_clkgen`

## Requirements
- R1: While reset is asserted and after it is released, `gen_clk_o`, `gen_rise_o` and `cfg_bad_o` are low and no rise occurs until an enabled, valid word is written.
- R2: Source select uses word bit 14 (primary select) and bit 13 (secondary select): bit 14 = 0 selects `src_tick_i[0]`; bit 14 = 1 with bit 13 = 0 selects `src_tick_i[1]`; bit 14 = 1 with bit 13 = 1 selects `src_tick_i[2]`.
- R3: The predivide code sits in word bits [9:8]; codes 1, 2 and 3 make one step every 4, 5 and 6 ticks of the selected source.
- R4: The divide value D sits in word bits [6:0] and is valid from 2 to 127; the output period is D steps, and the output is high for the first ceil(D/2) steps of each period.
- R5: `gen_rise_o` is a one-cycle pulse in the first cycle in which `gen_clk_o` is high after being low.
- R6: When enable bit 15 of the running word is clear, `gen_clk_o` stays low and no rise is produced.
- R7: A word with bit 15 set and either D below 2 or predivide code 0 raises `cfg_bad_o` in the cycle after the write, and once such a word is running the output stays low with no rise.
- R8: A word written while the output runs takes effect only at the end of the current period; that period completes with its old length and high time, including when the new word clears enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick_i | input | 3 | Tick enables of the three reference sources, each at twice its source rate |
| cfg_we_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 16 | Control word: [15] enable, [14] primary select, [13] secondary select, [9:8] predivide code, [6:0] divide value, other bits unused |
| gen_clk_o | output | 1 | Generated square-wave level |
| gen_rise_o | output | 1 | One-cycle pulse on each rising transition of the generated clock |
| cfg_bad_o | output | 1 | Pending word is enabled but holds an unusable setting |

## Verification
A wrong predivide count or divide count shows up at the ports within one output period. It appears as a rise interval or a high time that differs from D steps or ceil(D/2) steps, so the bench measures both for every pair of consecutive rises. A running word that changes at the wrong moment shows up in the period during which the write lands. That period is shortened, or the output falls early, so the bench writes in mid-period and measures that period exactly. Wrong idle or invalid handling shows up as rises or a high level during a quiet window of a few hundred cycles.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int DIV_W   = 7;
  localparam int CODE_W  = 2;
  localparam int SRC_N   = 3;
  localparam int SEL_W   = $clog2(SRC_N);
  localparam int STEP_W  = 3;
  localparam int WORD_W  = 16;
  localparam int CODE_BIAS = 3;

  typedef struct packed {
    logic              en;
    logic              pri_sel;
    logic              sec_sel;
    logic [2:0]        spare_hi;
    logic [CODE_W-1:0] code;
    logic              spare_lo;
    logic [DIV_W-1:0]  div;
  } word_t;

  function automatic logic word_usable(word_t w);
    return (w.code != '0) && (w.div >= DIV_W'(2));
  endfunction

  function automatic logic [SEL_W-1:0] word_src(word_t w);
    if (!w.pri_sel)     return SEL_W'(0);
    else if (!w.sec_sel) return SEL_W'(1);
    else                return SEL_W'(2);
  endfunction
endpackage

// File: rtl/hsp_word_regs.sv
module hsp_word_regs
  import hsp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  word_t  wdata_i,
  input  logic   period_end_i,
  output word_t  run_word_o,
  output logic   running_o,
  output logic   bad_o
);
  word_t pend_q, pend_d;
  word_t act_q, act_d;

  assign running_o = act_q.en && word_usable(act_q);
  assign bad_o     = pend_q.en && !word_usable(pend_q);
  assign run_word_o = act_q;

  always_comb begin
    pend_d = pend_q;
    if (we_i) pend_d = wdata_i;
    act_d = act_q;
    if (!running_o || period_end_i) act_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !period_end_i) |=> $stable(act_q)); // R8
endmodule

// File: rtl/hsp_src_mux.sv
module hsp_src_mux
  import hsp_pkg::*;
(
  input  logic [SRC_N-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  always_comb begin
    case (sel_i)
      SEL_W'(0): tick_o = tick_i[0];
      SEL_W'(1): tick_o = tick_i[1];
      SEL_W'(2): tick_o = tick_i[2];
      default:   tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hsp_prediv.sv
module hsp_prediv
  import hsp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              step_o
);
  logic [STEP_W-1:0] cnt_q, cnt_d;
  logic [STEP_W-1:0] limit;

  assign limit  = STEP_W'(code_i) + STEP_W'(CODE_BIAS);
  assign step_o = run_i && tick_i && (cnt_q == limit - STEP_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)       cnt_d = '0;
    else if (step_o)  cnt_d = '0;
    else if (tick_i)  cnt_d = cnt_q + STEP_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit)); // R3
endmodule

// File: rtl/hsp_outdiv.sv
module hsp_outdiv
  import hsp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             period_end_o,
  output logic             level_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] idx_q, idx_d;
  logic             lvl_q, lvl_d;
  logic             rise_q, rise_d;
  logic [DIV_W-1:0] high_steps;

  assign high_steps   = div_i - (div_i >> 1);
  assign period_end_o = step_i && (idx_q == div_i - DIV_W'(1));

  always_comb begin
    idx_d  = idx_q;
    lvl_d  = lvl_q;
    rise_d = 1'b0;
    if (!run_i) begin
      idx_d = '0;
      lvl_d = 1'b0;
    end else if (step_i) begin
      idx_d  = period_end_o ? '0 : idx_q + DIV_W'(1);
      lvl_d  = (idx_q < high_steps);
      rise_d = (idx_q == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = rise_q;

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (idx_q < div_i)); // R4
  AST_RISE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> (lvl_q && !$past(lvl_q))); // R5
  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |=> !rise_q); // R5
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !lvl_q); // R6
endmodule

// File: rtl/hsp_clkgen.sv
module hsp_clkgen
  import hsp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  src_tick_i,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic              gen_clk_o,
  output logic              gen_rise_o,
  output logic              cfg_bad_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  word_t      run_word;
  logic       running;
  logic       period_end;
  logic       sel_tick;
  logic       step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  hsp_word_regs i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .we_i         (cfg_we_i),
    .wdata_i      (word_t'(cfg_wdata_i)),
    .period_end_i (period_end),
    .run_word_o   (run_word),
    .running_o    (running),
    .bad_o        (cfg_bad_o)
  );

  hsp_src_mux i_mux (
    .tick_i (src_tick_i),
    .sel_i  (word_src(run_word)),
    .tick_o (sel_tick)
  );

  hsp_prediv i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (running),
    .tick_i (sel_tick),
    .code_i (run_word.code),
    .step_o (step)
  );

  hsp_outdiv i_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .run_i        (running),
    .step_i       (step),
    .div_i        (run_word.div),
    .period_end_o (period_end),
    .level_o      (gen_clk_o),
    .rise_o       (gen_rise_o)
  );

  AST_BAD_NEVER_RISES: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!running && !$past(running)) |-> !gen_rise_o); // R7
endmodule

// File: tb/test_hsp_clkgen.sv
module test_hsp_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int P0 = 5;
  localparam int P1 = 2;
  localparam int P2 = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_tick = 3'b000;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic        gclk, grise, bad;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct { int period; int high; string req; } exp_t;
  exp_t exp_q[$];

  hsp_clkgen i_hsp_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick),
    .cfg_we_i(we), .cfg_wdata_i(wdata),
    .gen_clk_o(gclk), .gen_rise_o(grise), .cfg_bad_o(bad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  int t0c = 0, t1c = 0, t2c = 0;
  always @(negedge clk) begin
    t0c = (t0c == P0-1) ? 0 : t0c + 1;
    t1c = (t1c == P1-1) ? 0 : t1c + 1;
    t2c = (t2c == P2-1) ? 0 : t2c + 1;
    src_tick <= {t2c == 0, t1c == 0, t0c == 0};
  end

  task automatic check_eq(int act, int expv, string req, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: measures each period and pops the expected item
  int last_rise = 0;
  int hi_cnt = 0;
  bit have_last = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (grise) begin
        if (have_last && exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check_eq(cyc - last_rise, e.period, e.req, "period");
          check_eq(hi_cnt, e.high, e.req, "high time");
        end
        last_rise = cyc;
        have_last = 1;
        hi_cnt = 1;
      end else if (gclk) begin
        hi_cnt++;
      end
    end
  end

  function automatic logic [15:0] mk(bit en, bit ps, bit ss, int code, int div);
    return {en, ps, ss, 3'b000, 2'(code), 1'b0, 7'(div)};
  endfunction

  task automatic write_word(logic [15:0] w);
    @(negedge clk);
    we = 1'b1;
    wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_rises(int n);
    for (int k = 0; k < n; k++) begin
      do @(negedge clk); while (!grise);
    end
  endtask

  task automatic push(int period, int high, string req);
    exp_t e;
    e.period = period; e.high = high; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic check_quiet(int n, string req);
    int rises = 0, highs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (grise) rises++;
      if (gclk) highs++;
    end
    check_eq(rises, 0, req, "rises in quiet window");
    check_eq(highs, 0, req, "high cycles in quiet window");
  endtask

  task automatic run_case(logic [15:0] w, int period, int high, int n, string req);
    write_word(w);
    wait_rises(2);
    @(negedge clk);
    for (int k = 0; k < n; k++) push(period, high, req);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq(gclk, 0, "R1", "level in reset");
    check_eq(grise, 0, "R1", "rise in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_eq(bad, 0, "R1", "flag after reset");
    check_quiet(100, "R1");

    // R2 R3 R4: source 0, code 1 (4 ticks), D=2: step 20, period 40, high 20
    run_case(mk(1, 0, 0, 1, 2), 40, 20, 2, "R2/R3/R4 src0");
    // source 1, code 2 (5 ticks), D=7: step 10, period 70, high 4 steps
    run_case(mk(1, 1, 0, 2, 7), 70, 40, 2, "R2/R3/R4 src1");
    // source 2, code 3 (6 ticks), D=3: step 18, period 54, high 2 steps
    run_case(mk(1, 1, 1, 3, 3), 54, 36, 2, "R2/R3/R4 src2");

    // R8: mid-period change keeps current period
    run_case(mk(1, 1, 0, 1, 20), 160, 80, 1, "R8 setup");
    wait_rises(1);
    repeat (30) @(negedge clk);
    write_word(mk(1, 1, 0, 1, 4));
    push(160, 80, "R8 old period");
    push(32, 16, "R8 new period");
    drain();

    // R8 with disable: period in flight finishes its high phase
    begin
      int t0;
      wait_rises(1);
      t0 = cyc;
      write_word(mk(0, 1, 0, 1, 4));
      while (cyc < t0 + 12) @(negedge clk);
      check_eq(gclk, 1, "R8", "level still high after disable write");
      while (cyc < t0 + 20) @(negedge clk);
      check_eq(gclk, 0, "R8", "level low at old fall time");
    end
    check_quiet(300, "R6");
    check_eq(bad, 0, "R6", "flag with enable clear");

    // R6: disabled valid word written from idle
    write_word(mk(0, 0, 0, 1, 10));
    check_eq(bad, 0, "R6", "flag disabled word");
    check_quiet(300, "R6");

    // R7: divide below 2
    write_word(mk(1, 1, 0, 1, 1));
    check_eq(bad, 1, "R7", "flag divide 1");
    check_quiet(300, "R7");
    // R7: predivide code 0
    write_word(mk(1, 1, 0, 0, 10));
    check_eq(bad, 1, "R7", "flag code 0");
    check_quiet(300, "R7");

    // R4 boundary: D=127, source 1, code 1: step 8, period 1016, high 64 steps
    run_case(mk(1, 1, 0, 1, 127), 1016, 512, 2, "R4 max divide");
    check_eq(bad, 0, "R7", "flag cleared by valid word");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule